// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host end of a one-wire debug link. A single open-drain line is shared with the target. The host starts every bit slot, whichever way the data flows. The engine accepts one byte-level request at a time. It runs eight consecutive bit slots, most significant bit first, and reports the end of the byte with a one-cycle done pulse.

Each slot is 16 clock cycles long and begins with the host pulling the line low. On a write bit, the low time carries the value: a short pull (4 cycles) means 1 and a long pull (13 cycles) means 0. On a read bit, the host gives a short start pull and then releases the line. The target may hold the line low to signal a 0. The engine passes the line through a two-flop synchroniser and captures the synchronised level at slot cycle 10.

The engine never drives the line high. Its single drive-enable output means "pull low", and the pad stays tri-stated at all other times. A synchronous reset abandons any transfer in progress and releases the line.

Top module: `onewire_dbg_host`

## Requirements
- R1: After synchronous reset, busy, done and lineDrvEn are all 0.
- R2: A write bit of value 1 holds lineDrvEn high for exactly 4 consecutive cycles at the start of its slot.
- R3: A write bit of value 0 holds lineDrvEn high for exactly 13 consecutive cycles at the start of its slot.
- R4: Every slot lasts 16 cycles and starts with lineDrvEn rising. A byte is 8 slots, so busy stays high for exactly 128 cycles after the cycle a request is accepted.
- R5: Write bits go out most significant first: slot k carries wrData[7-k], with k counted from 0.
- R6: On a read, each slot's start pull lasts 4 cycles and the line is then released. The synchronised line level captured at slot cycle 10 is shifted in MSB first. rdData holds the received byte once done has pulsed.
- R7: done is high for exactly one cycle, in the first cycle in which busy is low again after a transfer.
- R8: reqWrite and reqRead are ignored while busy is high: the slot pattern and the busy duration of the running transfer do not change.
- R9: Reset asserted during a transfer leaves busy, done and lineDrvEn at 0 in the following cycle. The next request then runs a normal transfer.
- R10: If reqWrite and reqRead are both high in an idle cycle, the write is performed.
- R11: lineDrvEn is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqWrite | input | 1 | Start a write of wrData (sampled when idle) |
| reqRead | input | 1 | Start a read of one byte (sampled when idle) |
| wrData | input | 8 | Byte to transmit |
| rdData | output | 8 | Received byte, valid after done |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a byte |
| lineDrvEn | output | 1 | 1 pulls the shared line low, 0 releases it |
| lineIn | input | 1 | Level of the shared line |

## Verification
Most internal faults in this engine show up on lineDrvEn within the slot where they occur. A wrong slot counter moves a release edge or the next start edge. A wrong transmit shift register gives a pulse width that does not match the expected bit. A wrong bit index stretches or shortens busy, and that appears at the end of the byte, 128 cycles after acceptance. Receive faults appear only at the end of a read, as an rdData byte that differs from what the modelled target sent. Sweeping all 256 byte values in both directions exposes single-bit and ordering errors.

// File: rtl/owdh_pkg.sv
package owdh_pkg;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic loadTx;      // capture wrData into the transmit shifter
    logic advTx;       // shift the transmit shifter by one bit
    logic startPulse;  // begin pulling the line low
    logic endShort;    // short-pulse release point
    logic endLong;     // long-pulse release point
    logic capRx;       // capture synchronised line into receive shifter
    logic isRead;      // current transfer is a read
  } strobe_t;

endpackage

// File: rtl/owdh_ctrl.sv
module owdh_ctrl
  import owdh_pkg::*;
#(
  parameter int SLOT_CYC  = 16,
  parameter int ONE_LOW   = 4,
  parameter int ZERO_LOW  = 13,
  parameter int SAMPLE_AT = 10,
  parameter int DATA_W    = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqWrite,
  input  logic    reqRead,
  output logic    busy,
  output logic    done,
  output strobe_t stb
);
  localparam int CW = $clog2(SLOT_CYC);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t        state;
  logic [CW-1:0] slotCnt;
  logic [BW-1:0] bitIdx;
  logic          opRead;
  logic          doneQ;

  logic accept, running, slotEnd, lastBit, byteEnd;

  assign running = (state == ST_RUN);
  assign accept  = (state == ST_IDLE) && (reqWrite || reqRead);
  assign slotEnd = running && (slotCnt == CW'(SLOT_CYC - 1));
  assign lastBit = (bitIdx == BW'(DATA_W - 1));
  assign byteEnd = slotEnd && lastBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      slotCnt <= '0;
      bitIdx  <= '0;
      opRead  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= byteEnd;
      if (accept) begin
        state   <= ST_RUN;
        slotCnt <= '0;
        bitIdx  <= '0;
        opRead  <= !reqWrite;   // write wins a tie
      end else if (running) begin
        if (slotEnd) begin
          slotCnt <= '0;
          if (lastBit) begin
            state  <= ST_IDLE;
            bitIdx <= '0;
          end else begin
            bitIdx <= bitIdx + BW'(1);
          end
        end else begin
          slotCnt <= slotCnt + CW'(1);
        end
      end
    end
  end

  always_comb begin
    stb            = '0;
    stb.loadTx     = accept && reqWrite;
    stb.advTx      = slotEnd;
    stb.startPulse = accept || (slotEnd && !lastBit);
    stb.endShort   = running && (slotCnt == CW'(ONE_LOW - 1));
    stb.endLong    = running && (slotCnt == CW'(ZERO_LOW - 1));
    stb.capRx      = running && opRead && (slotCnt == CW'(SAMPLE_AT));
    stb.isRead     = accept ? !reqWrite : opRead;
  end

  assign busy = running;
  assign done = doneQ;

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !byteEnd) |=> (busy && $stable(opRead)));

endmodule

// File: rtl/owdh_dpath.sv
module owdh_dpath
  import owdh_pkg::*;
#(
  parameter int SLOT_CYC    = 16,
  parameter int ONE_LOW     = 4,
  parameter int ZERO_LOW    = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lineIn,
  output logic [DATA_W-1:0] rdData,
  output logic              lineDrvEn
);
  localparam int LW = $clog2(SLOT_CYC) + 1;

  logic [DATA_W-1:0]      txShift;
  logic [DATA_W-1:0]      rxShift;
  logic                   drvQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineSync;

  // Synchroniser chain; idle level of the line is high.
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncQ[0] <= 1'b1;
          else     syncQ[0] <= lineIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncQ[gi] <= 1'b1;
          else     syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate
  assign lineSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
    end else if (stb.loadTx) begin
      txShift <= wrData;
    end else if (stb.advTx) begin
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift <= '0;
    end else if (stb.capRx) begin
      rxShift <= {rxShift[DATA_W-2:0], lineSync};
    end
  end

  // Open-drain pull: set at slot start, cleared at the short or long point.
  always_ff @(posedge clk) begin
    if (rst) begin
      drvQ <= 1'b0;
    end else if (stb.startPulse) begin
      drvQ <= 1'b1;
    end else if (stb.endShort && (stb.isRead || txShift[DATA_W-1])) begin
      drvQ <= 1'b0;
    end else if (stb.endLong) begin
      drvQ <= 1'b0;
    end
  end

  assign lineDrvEn = drvQ;
  assign rdData    = rxShift;

  // Checker counter: length of the current low pull.
  logic [LW-1:0] hiLen;
  always_ff @(posedge clk) begin
    if (rst)       hiLen <= '0;
    else if (drvQ) hiLen <= hiLen + LW'(1);
    else           hiLen <= '0;
  end

  // R2 R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!drvQ && hiLen != '0) |-> (hiLen == LW'(ONE_LOW) || hiLen == LW'(ZERO_LOW)));

  // R6
  read_short_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.isRead && !drvQ && hiLen != '0) |-> (hiLen == LW'(ONE_LOW)));

endmodule

// File: rtl/onewire_dbg_host.sv
module onewire_dbg_host
  import owdh_pkg::*;
#(
  parameter int SLOT_CYC    = 16,
  parameter int ONE_LOW     = 4,
  parameter int ZERO_LOW    = 13,
  parameter int SAMPLE_AT   = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqWrite,
  input  logic              reqRead,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              lineDrvEn,
  input  logic              lineIn
);
  strobe_t stb;

  owdh_ctrl #(
    .SLOT_CYC(SLOT_CYC), .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW),
    .SAMPLE_AT(SAMPLE_AT), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqWrite(reqWrite), .reqRead(reqRead),
    .busy(busy), .done(done), .stb(stb)
  );

  owdh_dpath #(
    .SLOT_CYC(SLOT_CYC), .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW),
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .lineIn(lineIn),
    .rdData(rdData), .lineDrvEn(lineDrvEn)
  );

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !lineDrvEn);

  // R4
  slot_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> lineDrvEn);

endmodule

// File: tb/sim_onewire_dbg_host.sv
module sim_onewire_dbg_host;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqWrite = 1'b0, reqRead = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic busy, done, lineDrvEn, lineIn;

  always #4 clk = ~clk;  // 125 MHz

  onewire_dbg_host u0 (
    .clk(clk), .rst(rst), .reqWrite(reqWrite), .reqRead(reqRead),
    .wrData(wrData), .rdData(rdData), .busy(busy), .done(done),
    .lineDrvEn(lineDrvEn), .lineIn(lineIn)
  );

  // Target model: pulls low after a host start edge when sending a 0.
  logic       tgtEn = 1'b0;
  logic [7:0] tgtByte = '0;
  int         tgtPtr = 0;
  logic       tgtPull = 1'b0;
  int         tgtCnt = 0;
  logic       prevDrv = 1'b0;

  assign lineIn = !(lineDrvEn || tgtPull);

  always @(posedge clk) begin
    prevDrv <= lineDrvEn;
    if (tgtEn && lineDrvEn && !prevDrv) begin
      tgtCnt  <= 1;
      tgtPull <= !tgtByte[7 - (tgtPtr % 8)];
      tgtPtr  <= tgtPtr + 1;
    end else if (tgtCnt != 0) begin
      tgtCnt <= tgtCnt + 1;
      if (tgtCnt == 12) begin
        tgtPull <= 1'b0;
        tgtCnt  <= 0;
      end
    end
  end

  int errors = 0;
  int checks = 0;
  longint cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Observation log of one transfer
  int  widths[16];
  int  rises[16];
  int  nW, nR, tick, hi, busyCyc, doneCnt;
  bit  doneAtFall, lastDrv;

  task automatic obs();
    if (lineDrvEn && !lastDrv) begin
      if (nR < 16) rises[nR] = tick;
      nR++;
    end
    if (lineDrvEn) hi++;
    else if (hi != 0) begin
      if (nW < 16) widths[nW] = hi;
      nW++;
      hi = 0;
    end
    lastDrv = lineDrvEn;
    tick++;
  endtask

  // Issue a request, optionally disturb it mid-flight, and log until the end.
  task automatic run(input bit w, input bit r, input logic [7:0] d,
                     input bit disturb);
    nW = 0; nR = 0; tick = 0; hi = 0; busyCyc = 0; doneCnt = 0;
    lastDrv = 1'b0; doneAtFall = 1'b0;
    @(negedge clk);
    reqWrite = w; reqRead = r; wrData = d;
    @(negedge clk);
    reqWrite = 1'b0; reqRead = 1'b0;
    wrData = ~d;
    forever begin
      obs();
      if (done) doneCnt++;
      if (busy) busyCyc++;
      else begin
        doneAtFall = done;
        break;
      end
      if (busyCyc > 200) break;
      if (disturb && busyCyc == 37) begin
        reqWrite = 1'b1; reqRead = 1'b1;
      end else begin
        reqWrite = 1'b0; reqRead = 1'b0;
      end
      @(negedge clk);
    end
    reqWrite = 1'b0; reqRead = 1'b0;
    @(negedge clk);
    if (done) doneCnt++;
  endtask

  task automatic checkWrite(input logic [7:0] v, input string tag);
    bit okW = (nW == 8);
    bit okS = (nR == 8);
    int firstBad = 0;
    for (int k = 0; k < 8 && k < nW; k++) begin
      int exp = v[7-k] ? 4 : 13;
      if (widths[k] != exp) begin okW = 0; firstBad = widths[k]; end
    end
    for (int k = 1; k < 8 && k < nR; k++)
      if (rises[k] - rises[k-1] != 16) okS = 0;
    chk(okW, {tag, " R2/R3/R5 write pulse widths MSB first"}, firstBad, v);
    chk(okS && busyCyc == 128, {tag, " R4 slot spacing and busy length"}, busyCyc, 128);
    chk(doneCnt == 1 && doneAtFall, {tag, " R7 done single pulse"}, doneCnt, 1);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !lineDrvEn, "R1 reset outputs", {busy, done, lineDrvEn}, 0);

    // R11 idle: line never driven
    begin
      bit ok = 1;
      repeat (20) begin
        @(negedge clk);
        if (lineDrvEn || busy) ok = 0;
      end
      chk(ok, "R11 idle release", lineDrvEn, 0);
    end

    // R2 R3 R4 R5 R7: exhaustive writes
    tgtEn = 1'b0;
    begin
      int bad = 0;
      for (int v = 0; v < 256; v++) begin
        int e0 = errors;
        run(1'b1, 1'b0, v[7:0], 1'b0);
        checkWrite(v[7:0], "write");
        if (errors != e0) bad++;
      end
      chk(bad == 0, "R5 write sweep bytes with errors", bad, 0);
    end

    // R6: exhaustive reads
    tgtEn = 1'b1;
    for (int v = 0; v < 256; v++) begin
      bit okP = (nW == 0);
      tgtByte = v[7:0]; tgtPtr = 0;
      run(1'b0, 1'b1, 8'h00, 1'b0);
      okP = (nW == 8);
      for (int k = 0; k < 8 && k < nW; k++) if (widths[k] != 4) okP = 0;
      chk(okP, "R6 read start pulses 4 cycles", nW, 8);
      chk(rdData == v[7:0], "R6 read data", rdData, v);
      chk(busyCyc == 128 && doneCnt == 1, "R4/R7 read framing", busyCyc, 128);
      @(negedge clk);
    end
    tgtEn = 1'b0;

    // R10: simultaneous requests -> write
    run(1'b1, 1'b1, 8'h3C, 1'b0);
    checkWrite(8'h3C, "R10 tie");

    // R8: requests while busy ignored
    run(1'b1, 1'b0, 8'hA5, 1'b1);
    checkWrite(8'hA5, "R8 busy ignore");
    chk(!busy && !lineDrvEn, "R8 no restart after byte", busy, 0);

    // R9: reset mid-transfer
    @(negedge clk);
    reqWrite = 1'b1; wrData = 8'h00;
    @(negedge clk);
    reqWrite = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !lineDrvEn, "R9 reset mid-transfer", {busy, done, lineDrvEn}, 0);
    @(negedge clk);
    chk(!busy && !lineDrvEn, "R9 stays idle", {busy, lineDrvEn}, 0);
    run(1'b1, 1'b0, 8'h81, 1'b0);
    checkWrite(8'h81, "R9 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule